// File: doc/BRIEF.md
# Peer Doorbell Interrupt Register Block

This block gives one node, which shares a memory region with a group of peer nodes, a small set of 32-bit registers on a simple read/write bus. Each register sits at a byte offset that is a multiple of four. The block has two jobs. It sends doorbell requests to peers. It turns doorbell events that arrive from peers into interrupts for the local node.

The node ID register tells software which number this node holds. Until the node has been brought up, it reads as all ones.

A write to the doorbell register creates one outgoing request. The request carries a destination node number and a vector, and leaves the block through a valid/ready port.

Incoming events are handled according to a mode input that is fixed while the block runs:
- In pin mode, an event latches a single status bit. That bit, gated by mask bit 0, drives a level interrupt output.
- In message mode, an event with a vector below the configured count produces a one-cycle pulse on that vector's output line. Status is left unchanged. An event whose vector is out of range is dropped and sets a sticky error flag.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset, mask and status read 0, `dbValid` is low, `vecPulse` is all zero, `vecError` is low and `intrOut` is low.
- R2: The mask register at byte offset 0 stores all 32 bits written to it and reads them back unchanged.
- R3: In pin mode, an incoming event (`evtValid` high for one cycle) sets status (offset 4) to 1 from the next clock edge, whatever the value of `evtVector`. The event produces no `vecPulse`.
- R4: In pin mode, `intrOut` is high exactly when mask bit 0 and status are both 1. Mask bits 31:1 have no effect on it.
- R5: A bus read of status returns its current value, and the read clears status to 0 at the accepting edge. If an event arrives in the same cycle, the event wins and status stays 1.
- R6: The node ID register (offset 8) reads as `nodeId` zero-extended to 32 bits while `nodeReady` is high, and as 0xFFFFFFFF while it is low.
- R7: A doorbell write (offset 12) raises `dbValid` at the next edge. `dbDest` carries write bits 31:16 and `dbVector` carries write bits 15:0. Both are held stable until `dbReady` is seen high. Each write gives exactly one handshake.
- R8: While an earlier doorbell request is still unaccepted, a new doorbell write is stalled: `busAck` stays low until the cycle after the handshake.
- R9: In message mode, an event with a vector v below `NUM_VEC` sets `vecPulse[v]` high for exactly one cycle, starting at the next edge. The event leaves status unchanged, and `intrOut` stays low whatever the mask holds.
- R10: In message mode, an event with a vector of `NUM_VEC` or more produces no pulse and sets `vecError`. `vecError` then stays high until reset.
- R11: Writes to status and node ID have no effect. Reads of the doorbell offset and of any offset that is not a register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgMode | input | 1 | 1 = message mode, 0 = pin mode; static between resets |
| nodeReady | input | 1 | Node ID is valid |
| nodeId | input | 16 | Assigned node number |
| busReq | input | 1 | Bus access request, held until acknowledged |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busAck is high |
| busAck | output | 1 | Access accepted at this clock edge |
| dbValid | output | 1 | Outgoing doorbell request pending |
| dbReady | input | 1 | Transport accepts the request |
| dbDest | output | 16 | Destination node of the request |
| dbVector | output | 16 | Vector of the request |
| evtValid | input | 1 | Incoming event strobe |
| evtVector | input | 16 | Vector of the incoming event |
| intrOut | output | 1 | Pin-mode level interrupt |
| vecPulse | output | 4 | Per-vector one-cycle pulses in message mode |
| vecError | output | 1 | Sticky flag for an out-of-range event vector |

## Verification
The interrupt path is driven with a table of mask values and event choices. The table pairs masks that differ only in bit 0 with masks that differ only in the upper bits, which shows that only bit 0 gates the output. It also includes cases with no event, which shows that status, not the mask, is the source of the interrupt.

Incoming events are sent in both modes with the same vectors. In pin mode, any vector sets status. In message mode, a vector only pulses its own line, and a vector equal to the count, or one far above it, raises the error flag instead of a pulse.

Doorbell writes are issued while the transport holds off ready. This separates a correct stall-and-hold from a dropped or duplicated request.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  localparam int OFS_MASK   = 0;
  localparam int OFS_STATUS = 4;
  localparam int OFS_ID     = 8;
  localparam int OFS_DB     = 12;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2,
    RD_ID     = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic   maskWr;
    logic   statusRd;
    logic   dbWr;
    rdSel_t rdSel;
  } pdbStrobes_t;

endpackage

// File: rtl/pdb_ctrl.sv
module pdb_ctrl
  import pdb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              dbBusy,
  output logic              busAck,
  output pdbStrobes_t       strobes
);

  logic hitMask, hitStatus, hitId, hitDb;
  logic stallDb;

  assign hitMask   = (busAddr == ADDR_W'(OFS_MASK));
  assign hitStatus = (busAddr == ADDR_W'(OFS_STATUS));
  assign hitId     = (busAddr == ADDR_W'(OFS_ID));
  assign hitDb     = (busAddr == ADDR_W'(OFS_DB));

  assign stallDb = busWe && hitDb && dbBusy;
  assign busAck  = busReq && !stallDb;

  always_comb begin
    strobes.maskWr   = busAck && busWe && hitMask;
    strobes.statusRd = busAck && !busWe && hitStatus;
    strobes.dbWr     = busAck && busWe && hitDb;
    if (busWe)          strobes.rdSel = RD_ZERO;
    else if (hitMask)   strobes.rdSel = RD_MASK;
    else if (hitStatus) strobes.rdSel = RD_STATUS;
    else if (hitId)     strobes.rdSel = RD_ID;
    else                strobes.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/pdb_datapath.sv
module pdb_datapath
  import pdb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16,
  parameter int VEC_W   = 16,
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msgMode,
  input  logic               nodeReady,
  input  logic [ID_W-1:0]    nodeId,
  input  pdbStrobes_t        strobes,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               dbValid,
  input  logic               dbReady,
  output logic [ID_W-1:0]    dbDest,
  output logic [VEC_W-1:0]   dbVector,
  input  logic               evtValid,
  input  logic [VEC_W-1:0]   evtVector,
  output logic               intrOut,
  output logic [NUM_VEC-1:0] vecPulse,
  output logic               vecError
);

  localparam logic [VEC_W:0] VEC_LIMIT = (VEC_W+1)'(NUM_VEC);

  logic [DATA_W-1:0] maskReg;
  logic              statusBit;
  logic              pinEvt, msgEvt, vecOutOfRange;

  assign pinEvt        = evtValid && !msgMode;
  assign msgEvt        = evtValid && msgMode;
  assign vecOutOfRange = ({1'b0, evtVector} >= VEC_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN)                 maskReg <= '0;
    else if (strobes.maskWr)   maskReg <= busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 statusBit <= 1'b0;
    else if (pinEvt)           statusBit <= 1'b1;
    else if (strobes.statusRd) statusBit <= 1'b0;
  end

  assign intrOut = !msgMode && (|(maskReg & DATA_W'(statusBit)));

  always_ff @(posedge clk) begin
    if (!rstN)                           vecError <= 1'b0;
    else if (msgEvt && vecOutOfRange)    vecError <= 1'b1;
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : gVec
    always_ff @(posedge clk) begin
      if (!rstN) vecPulse[v] <= 1'b0;
      else       vecPulse[v] <= msgEvt && (evtVector == VEC_W'(v));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbValid  <= 1'b0;
      dbDest   <= '0;
      dbVector <= '0;
    end else if (strobes.dbWr) begin
      dbValid  <= 1'b1;
      dbDest   <= busWdata[VEC_W +: ID_W];
      dbVector <= busWdata[VEC_W-1:0];
    end else if (dbValid && dbReady) begin
      dbValid  <= 1'b0;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_MASK:   busRdata = maskReg;
      RD_STATUS: busRdata = DATA_W'(statusBit);
      RD_ID:     busRdata = nodeReady ? DATA_W'(nodeId) : '1;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import pdb_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16,
  parameter int VEC_W   = 16,
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msgMode,
  input  logic               nodeReady,
  input  logic [ID_W-1:0]    nodeId,
  input  logic               busReq,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               busAck,
  output logic               dbValid,
  input  logic               dbReady,
  output logic [ID_W-1:0]    dbDest,
  output logic [VEC_W-1:0]   dbVector,
  input  logic               evtValid,
  input  logic [VEC_W-1:0]   evtVector,
  output logic               intrOut,
  output logic [NUM_VEC-1:0] vecPulse,
  output logic               vecError
);

  pdbStrobes_t strobes;

  pdb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busReq  (busReq),
    .busWe   (busWe),
    .busAddr (busAddr),
    .dbBusy  (dbValid),
    .busAck  (busAck),
    .strobes (strobes)
  );

  pdb_datapath #(
    .DATA_W(DATA_W), .ID_W(ID_W), .VEC_W(VEC_W), .NUM_VEC(NUM_VEC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .msgMode   (msgMode),
    .nodeReady (nodeReady),
    .nodeId    (nodeId),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .dbValid   (dbValid),
    .dbReady   (dbReady),
    .dbDest    (dbDest),
    .dbVector  (dbVector),
    .evtValid  (evtValid),
    .evtVector (evtVector),
    .intrOut   (intrOut),
    .vecPulse  (vecPulse),
    .vecError  (vecError)
  );

endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16,
  parameter int VEC_W   = 16,
  parameter int NUM_VEC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               msgMode,
  input logic               busReq,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busAck,
  input logic               dbValid,
  input logic               dbReady,
  input logic [ID_W-1:0]    dbDest,
  input logic [VEC_W-1:0]   dbVector,
  input logic               evtValid,
  input logic               intrOut,
  input logic [NUM_VEC-1:0] vecPulse,
  input logic               vecError
);

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dbValid && !dbReady) |=> (dbValid && $stable(dbDest) && $stable(dbVector))); // R7

  AST_DB_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && busAddr == ADDR_W'(12) && dbValid) |-> !busAck); // R8

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && !busWe && busAddr == ADDR_W'(4) && !evtValid) |=> !intrOut); // R5

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vecPulse)); // R9

  AST_MSG_NO_INTR: assert property (@(posedge clk) disable iff (!rstN)
    msgMode |-> !intrOut); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    vecError |=> vecError); // R10

  AST_PIN_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!msgMode && evtValid) |=> (vecPulse == '0)); // R3

endmodule

bind peer_doorbell_regs pdb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .VEC_W(VEC_W), .NUM_VEC(NUM_VEC)
) u_chk (.*);

// File: tb/tb_peer_doorbell_regs.sv
module tb_peer_doorbell_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgMode = 1'b0;
  logic        nodeReady = 1'b0;
  logic [15:0] nodeId = 16'h0000;
  logic        busReq = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        busAck;
  logic        dbValid;
  logic        dbReady = 1'b0;
  logic [15:0] dbDest;
  logic [15:0] dbVector;
  logic        evtValid = 1'b0;
  logic [15:0] evtVector = 16'h0;
  logic        intrOut;
  logic [3:0]  vecPulse;
  logic        vecError;

  int tests = 0;
  int fails = 0;
  int handshakes = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  peer_doorbell_regs dut (.*);

  always @(posedge clk) begin
    if (!rstN) handshakes <= 0;
    else if (dbValid && dbReady) handshakes <= handshakes + 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; msgMode = mode;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    #1;
    while (!busAck) begin @(negedge clk); #1; end
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    @(negedge clk);
    busReq = 1'b0;
  endtask

  task automatic sendEvent(input logic [15:0] v);
    @(negedge clk);
    evtValid = 1'b1; evtVector = v;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  // mask, send event, expected intrOut
  localparam logic [33:0] INTR_TABLE [6] = '{
    {32'h0000_0001, 1'b1, 1'b1},
    {32'h0000_0000, 1'b1, 1'b0},
    {32'hFFFF_FFFE, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 1'b1, 1'b1},
    {32'h0000_0001, 1'b0, 1'b0},
    {32'h8000_0003, 1'b0, 1'b0}
  };

  initial begin
    doReset(1'b0);
    @(negedge clk); #1;
    chk("R1 dbValid", {31'b0, dbValid}, 32'h0);
    chk("R1 intrOut", {31'b0, intrOut}, 32'h0);
    chk("R1 vecPulse", {28'b0, vecPulse}, 32'h0);
    chk("R1 vecError", {31'b0, vecError}, 32'h0);
    busRead(4'd0, rd);  chk("R1 mask", rd, 32'h0);
    busRead(4'd4, rd);  chk("R1 status", rd, 32'h0);

    busWrite(4'd0, 32'hA5C3_0F96);
    busRead(4'd0, rd);  chk("R2 mask readback", rd, 32'hA5C3_0F96);

    // R4 table walk
    foreach (INTR_TABLE[i]) begin
      busRead(4'd4, rd);
      busWrite(4'd0, INTR_TABLE[i][33:2]);
      if (INTR_TABLE[i][1]) sendEvent(16'(i * 7));
      #1;
      chk($sformatf("R4 intrOut row %0d", i), {31'b0, intrOut}, {31'b0, INTR_TABLE[i][0]});
    end

    // R3 pin mode: arbitrary vector sets status, no pulse
    busRead(4'd4, rd);
    @(negedge clk);
    evtValid = 1'b1; evtVector = 16'hBEEF;
    @(negedge clk);
    evtValid = 1'b0;
    #1;
    chk("R3 no vecPulse", {28'b0, vecPulse}, 32'h0);
    busRead(4'd4, rd);  chk("R3 status set", rd, 32'h1);
    busRead(4'd4, rd);  chk("R5 status cleared by read", rd, 32'h0);

    // R5 event in same cycle as status read wins
    sendEvent(16'h0001);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b0; busAddr = 4'd4; evtValid = 1'b1;
    #1; rd = busRdata;
    chk("R5 read value", rd, 32'h1);
    @(negedge clk);
    busReq = 1'b0; evtValid = 1'b0;
    busRead(4'd4, rd);  chk("R5 event wins over clear", rd, 32'h1);

    // R11 ignored writes and zero reads
    busWrite(4'd4, 32'h0000_0000);
    busRead(4'd4, rd);  chk("R11 status write ignored", rd, 32'h0);
    busRead(4'd4, rd);
    busWrite(4'd4, 32'hFFFF_FFFF);
    busRead(4'd4, rd);  chk("R11 status write no set", rd, 32'h0);
    nodeReady = 1'b1; nodeId = 16'h0123;
    busWrite(4'd8, 32'h0000_0055);
    busRead(4'd8, rd);  chk("R11 id write ignored", rd, 32'h0000_0123);
    busRead(4'd12, rd); chk("R11 doorbell reads 0", rd, 32'h0);
    busRead(4'd5, rd);  chk("R11 unmapped reads 0", rd, 32'h0);

    // R6 node ID
    nodeReady = 1'b0;
    busRead(4'd8, rd);  chk("R6 not ready", rd, 32'hFFFF_FFFF);
    nodeReady = 1'b1; nodeId = 16'hFFFE;
    busRead(4'd8, rd);  chk("R6 ready", rd, 32'h0000_FFFE);

    // R7 / R8 doorbell
    dbReady = 1'b0;
    busWrite(4'd12, 32'h0005_ABCD);
    #1;
    chk("R7 dbValid", {31'b0, dbValid}, 32'h1);
    chk("R7 dbDest", {16'b0, dbDest}, 32'h5);
    chk("R7 dbVector", {16'b0, dbVector}, 32'hABCD);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b1; busAddr = 4'd12; busWdata = 32'h0007_0002;
    #1; chk("R8 stall", {31'b0, busAck}, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    chk("R8 still stalled", {31'b0, busAck}, 32'h0);
    chk("R7 dest held", {16'b0, dbDest}, 32'h5);
    dbReady = 1'b1;
    #1; chk("R8 stall on handshake cycle", {31'b0, busAck}, 32'h0);
    @(negedge clk); #1;
    chk("R7 cleared after handshake", {31'b0, dbValid}, 32'h0);
    chk("R8 accepted after handshake", {31'b0, busAck}, 32'h1);
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
    #1;
    chk("R7 second dest", {16'b0, dbDest}, 32'h7);
    chk("R7 second vector", {16'b0, dbVector}, 32'h2);
    @(negedge clk);
    dbReady = 1'b0;
    #1;
    chk("R7 handshake count", handshakes, 32'd2);
    chk("R7 no extra request", {31'b0, dbValid}, 32'h0);

    // R9 / R10 message mode
    doReset(1'b1);
    busWrite(4'd0, 32'h0000_0001);
    @(negedge clk);
    evtValid = 1'b1; evtVector = 16'd2;
    @(negedge clk);
    evtValid = 1'b0;
    #1; chk("R9 pulse vector 2", {28'b0, vecPulse}, 32'h4);
    chk("R9 no intr", {31'b0, intrOut}, 32'h0);
    @(negedge clk); #1;
    chk("R9 pulse one cycle", {28'b0, vecPulse}, 32'h0);
    busRead(4'd4, rd);  chk("R9 status untouched", rd, 32'h0);
    sendEvent(16'd0);
    #1; chk("R9 pulse vector 0", {28'b0, vecPulse}, 32'h1);
    sendEvent(16'd4);
    #1;
    chk("R10 no pulse at limit", {28'b0, vecPulse}, 32'h0);
    chk("R10 error set", {31'b0, vecError}, 32'h1);
    sendEvent(16'd3);
    #1;
    chk("R9 pulse vector 3", {28'b0, vecPulse}, 32'h8);
    chk("R10 error sticky", {31'b0, vecError}, 32'h1);
    sendEvent(16'h8001);
    #1; chk("R10 far vector dropped", {28'b0, vecPulse}, 32'h0);
    doReset(1'b1);
    #1; chk("R10 error cleared by reset", {31'b0, vecError}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule